// File: doc/BRIEF.md
# Tick Interval Timer

This block produces a periodic tick interrupt for a real-time clock subsystem. A 32768 Hz reference arrives as a one-cycle enable pulse, `refTick`, on the system clock. A power-of-two prescaler divides that pulse stream. The prescaled pulses then count down a programmed tick count. Each time the count runs out, the block latches an interrupt, holds the level interrupt output high, and reloads the count so that the ticks repeat.

Software uses four word registers, selected by a 2-bit address. The encodings are listed in the requirements. Reads are combinational from the address. Writes take effect at the clock edge on which `wrEn` is high. The timer starts only on a rising edge of its own enable while the global enable is set and a count is present. It stops when either of those two enables falls. Software clears the interrupt by writing a one to it.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, all four registers read zero, `tickIrq` is low and the counter is stopped.
- R2: A write to the count register (address 1) stores the value only when it is greater than 2. A write of 0, 1 or 2 leaves the previous value in place.
- R3: The counter starts only on a write to the control register (address 0) that raises the tick enable (bit 8) while bit 0 (global enable) of the written value is 1 and the stored count is nonzero. On start, the live count (address 2) reads the stored count. A control write that leaves the tick enable at 1 does not restart the counter.
- R4: The counter steps once every 2^N reference pulses, where N is control bits [7:4]. With N = 0, every reference pulse is one step.
- R5: Each step decrements the live count. A step taken when the live count is 1 is an expiry. An expiry reloads the live count from the count register, using the value held at that moment, and sets pending bit 0 (address 3).
- R6: A control write that lowers the tick enable, or lowers the global enable, stops the counter. The live count then reads 0, and further reference pulses cause no expiry.
- R7: A write to the pending register with bit 0 set clears the pending bit and lowers `tickIrq`. A write with bit 0 clear changes nothing.
- R8: If an expiry and a write-one clear fall in the same cycle, the pending bit stays set.
- R9: A change to N while the counter runs takes effect at the next prescaler period boundary. The period already in progress completes at the old length.
- R10: `tickIrq` is a level output that is high exactly while pending bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refTick | input | 1 | One-cycle enable per reference period (32768 Hz) |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register select for read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| tickIrq | output | 1 | Level tick interrupt |

## Verification
An expiry and a software clear of the pending bit can land on the same clock edge. The bench provokes this by driving the final prescaled reference pulse of a period in the same cycle as a write of one to the pending register. It expects the pending bit to read 1, `tickIrq` to stay high, and the live count to be reloaded. The bench also changes the prescale select partway through a period and checks that the live count holds for the remaining old-length period before it steps at the new rate.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Register addresses
  localparam int REG_CTRL  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_LIVE  = 2;
  localparam int REG_PEND  = 3;

  // Control field positions
  localparam int BIT_GLOB = 0;
  localparam int SEL_LSB  = 4;
  localparam int BIT_TICK = 8;

  // Pending bit position
  localparam int BIT_PEND = 0;

  // Smallest count value that a write may store
  localparam int MIN_COUNT = 3;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic start;
    logic stop;
  } tickStrb_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic [CNT_W-1:0]  liveCount,
  output tickStrb_t         strb,
  output logic [SEL_W-1:0]  selIn,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] rdData,
  output logic              tickIrq
);

  logic             globQ;
  logic             tickQ;
  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] countQ;
  logic             pendQ;

  logic wrCtrl;
  logic wrCount;
  logic wrPend;
  logic newGlob;
  logic newTick;

  assign wrCtrl  = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign wrCount = wrEn && (addr == ADDR_W'(REG_COUNT));
  assign wrPend  = wrEn && (addr == ADDR_W'(REG_PEND));
  assign newGlob = wrData[BIT_GLOB];
  assign newTick = wrData[BIT_TICK];

  // A start needs a rising tick enable, the global enable in the written value, and a count
  always_comb begin
    strb.start = wrCtrl && newGlob && newTick && !tickQ && (countQ != '0);
    strb.stop  = wrCtrl && ((tickQ && !newTick) || (globQ && !newGlob));
  end

  // The datapath samples the select only at a start or a period boundary
  assign selIn     = wrCtrl ? wrData[SEL_LSB +: SEL_W] : selQ;
  assign reloadVal = countQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      globQ <= 1'b0;
      tickQ <= 1'b0;
      selQ  <= '0;
    end else if (wrCtrl) begin
      globQ <= newGlob;
      tickQ <= newTick;
      selQ  <= wrData[SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (wrCount && (wrData >= DATA_W'(MIN_COUNT))) begin
      countQ <= wrData[CNT_W-1:0];
    end
  end

  // An expiry wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= 1'b0;
    end else if (expire) begin
      pendQ <= 1'b1;
    end else if (wrPend && wrData[BIT_PEND]) begin
      pendQ <= 1'b0;
    end
  end

  assign tickIrq = pendQ;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_CTRL): begin
        rdData[BIT_GLOB]          = globQ;
        rdData[BIT_TICK]          = tickQ;
        rdData[SEL_LSB +: SEL_W]  = selQ;
      end
      ADDR_W'(REG_COUNT): rdData = DATA_W'(countQ);
      ADDR_W'(REG_LIVE):  rdData = DATA_W'(liveCount);
      ADDR_W'(REG_PEND):  rdData[BIT_PEND] = pendQ;
      default:            rdData = '0;
    endcase
  end

endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  tickStrb_t        strb,
  input  logic [SEL_W-1:0] selIn,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             refTick,
  output logic             expire,
  output logic             running,
  output logic [CNT_W-1:0] liveCount
);

  // The widest divide is 2^(2^SEL_W - 1)
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] cnt;
  logic             runQ;
  logic             boundary;
  logic             lastStep;
  logic             step;

  // Prescaler terminal value: the low activeSel bits set
  for (genvar i = 0; i < PRE_W; i++) begin : g_lim
    assign preLimit[i] = (32'(i) < 32'(activeSel));
  end

  assign boundary = (preCnt == preLimit);
  assign step     = runQ && refTick && boundary && !strb.stop && !strb.start;
  assign lastStep = (cnt <= CNT_W'(1));
  assign expire   = step && lastStep;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ      <= 1'b0;
      cnt       <= '0;
      preCnt    <= '0;
      activeSel <= '0;
    end else if (strb.stop) begin
      runQ   <= 1'b0;
      cnt    <= '0;
      preCnt <= '0;
    end else if (strb.start) begin
      runQ      <= 1'b1;
      cnt       <= reloadVal;
      preCnt    <= '0;
      activeSel <= selIn;
    end else if (runQ && refTick) begin
      if (boundary) begin
        preCnt    <= '0;
        activeSel <= selIn;
        cnt       <= lastStep ? reloadVal : (cnt - CNT_W'(1));
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign running   = runQ;
  assign liveCount = cnt;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              tickIrq
);

  tickStrb_t        strb;
  logic [SEL_W-1:0] selIn;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] liveCount;
  logic             expire;
  logic             running;

  tick_timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .liveCount(liveCount), .strb(strb), .selIn(selIn),
    .reloadVal(reloadVal), .rdData(rdData), .tickIrq(tickIrq)
  );

  tick_timer_datapath #(
    .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .selIn(selIn), .reloadVal(reloadVal),
    .refTick(refTick), .expire(expire), .running(running), .liveCount(liveCount)
  );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              tickIrq,
  input logic              strbStart,
  input logic              strbStop,
  input logic              expire,
  input logic              running,
  input logic [CNT_W-1:0]  liveCount,
  input logic [CNT_W-1:0]  reloadVal
);

  logic clrWr;
  logic smallWr;
  assign clrWr   = wrEn && (addr == ADDR_W'(REG_PEND)) && wrData[BIT_PEND];
  assign smallWr = wrEn && (addr == ADDR_W'(REG_COUNT)) && (wrData < DATA_W'(MIN_COUNT));

  p_strb_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(strbStart && strbStop));

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    strbStart |=> (running && liveCount == $past(reloadVal)));

  p_small_kept_r2: assert property (@(posedge clk) disable iff (rst)
    smallWr |=> $stable(reloadVal));

  p_expire_irq_r5: assert property (@(posedge clk) disable iff (rst)
    expire |=> tickIrq);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tickIrq) |-> $past(expire));

  p_live_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    running |-> (liveCount != '0));

  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    strbStop |=> (!running && liveCount == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clrWr && !expire) |=> !tickIrq);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tickIrq && !clrWr) |=> tickIrq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clrWr && expire) |=> tickIrq);

endmodule

bind tick_timer tick_timer_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .tickIrq(tickIrq), .strbStart(strb.start), .strbStop(strb.stop),
  .expire(expire), .running(running), .liveCount(liveCount), .reloadVal(reloadVal)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/100ps
module tick_timer_test;

  localparam int AW = 2;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CTRL  = 2'd0;
  localparam logic [AW-1:0] A_COUNT = 2'd1;
  localparam logic [AW-1:0] A_LIVE  = 2'd2;
  localparam logic [AW-1:0] A_PEND  = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          refTick = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          tickIrq;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst(rst), .refTick(refTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickIrq(tickIrq)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          irq;
    string         tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // Driver: one bus cycle, inputs change 1 ns after the edge
  task automatic cyc(input logic we, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic rt);
    @(posedge clk); #1;
    wrEn = we; addr = a; wrData = d; refTick = rt;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic refs(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, addr, '0, 1'b1);
  endtask

  // Driver pushes the expected read; the monitor compares it at the falling edge
  task automatic chk(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic irq, input string tag);
    item_t it;
    @(posedge clk); #1;
    wrEn = 1'b0; refTick = 1'b0; addr = a;
    it.data = d; it.irq = irq; it.tag = tag;
    expQ.push_back(it);
  endtask

  item_t got;
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      got = expQ.pop_front();
      checks++;
      if (rdData !== got.data || tickIrq !== got.irq) begin
        fails++;
        $display("FAIL %s: rdData=%h tickIrq=%b expected rdData=%h tickIrq=%b",
                 got.tag, rdData, tickIrq, got.data, got.irq);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): run not finished, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk(A_CTRL,  32'h0, 1'b0, "R1 ctrl after reset");
    chk(A_COUNT, 32'h0, 1'b0, "R1 count after reset");
    chk(A_LIVE,  32'h0, 1'b0, "R1 live after reset");
    chk(A_PEND,  32'h0, 1'b0, "R1 pend after reset");

    // R3: no start while the count is zero
    wr(A_CTRL, 32'h101);
    chk(A_LIVE, 32'h0, 1'b0, "R3 no start with zero count");
    refs(3);
    chk(A_LIVE, 32'h0, 1'b0, "R3 still idle after pulses");
    wr(A_CTRL, 32'h0);

    // R2 count validation
    wr(A_COUNT, 32'd2);
    chk(A_COUNT, 32'd0, 1'b0, "R2 value 2 rejected");
    wr(A_COUNT, 32'd1);
    chk(A_COUNT, 32'd0, 1'b0, "R2 value 1 rejected");
    wr(A_COUNT, 32'd5);
    chk(A_COUNT, 32'd5, 1'b0, "R2 value 5 stored");
    wr(A_COUNT, 32'd2);
    chk(A_COUNT, 32'd5, 1'b0, "R2 old value kept");
    wr(A_COUNT, 32'd3);
    chk(A_COUNT, 32'd3, 1'b0, "R2 value 3 stored");

    // R3: global enable must be set
    wr(A_CTRL, 32'h100);
    chk(A_LIVE, 32'h0, 1'b0, "R3 no start without global enable");
    wr(A_CTRL, 32'h000);
    wr(A_CTRL, 32'h001);
    chk(A_LIVE, 32'h0, 1'b0, "R3 no start without tick enable");
    wr(A_CTRL, 32'h101);
    chk(A_LIVE, 32'd3, 1'b0, "R3 start loads count");
    chk(A_CTRL, 32'h101, 1'b0, "R3 control readback");

    // R4 with N = 0 and R5 expiry
    refs(1);
    chk(A_LIVE, 32'd2, 1'b0, "R4 step per pulse N=0");
    refs(1);
    chk(A_LIVE, 32'd1, 1'b0, "R4 second step");
    refs(1);
    chk(A_LIVE, 32'd3, 1'b1, "R5 expiry reloads, irq raised");
    chk(A_PEND, 32'd1, 1'b1, "R10 pending matches irq");

    // R7 clear semantics
    wr(A_PEND, 32'h0);
    chk(A_PEND, 32'd1, 1'b1, "R7 write zero ignored");
    wr(A_PEND, 32'h1);
    chk(A_PEND, 32'd0, 1'b0, "R7 write one clears");

    // R8 expiry and clear together
    refs(2);
    chk(A_LIVE, 32'd1, 1'b0, "R8 setup live 1");
    cyc(1'b1, A_PEND, 32'h1, 1'b1);
    chk(A_PEND, 32'd1, 1'b1, "R8 expiry wins over clear");
    chk(A_LIVE, 32'd3, 1'b1, "R8 reload on same cycle");
    wr(A_PEND, 32'h1);
    chk(A_PEND, 32'd0, 1'b0, "R7 clear after R8");

    // R6 stop on tick enable fall
    wr(A_CTRL, 32'h001);
    chk(A_LIVE, 32'd0, 1'b0, "R6 tick enable fall stops");
    refs(5);
    chk(A_LIVE, 32'd0, 1'b0, "R6 no activity while stopped");

    // R4 with N = 2
    wr(A_CTRL, 32'h121);
    chk(A_LIVE, 32'd3, 1'b0, "R3 restart with N=2");
    refs(3);
    chk(A_LIVE, 32'd3, 1'b0, "R4 no step before 4 pulses");
    refs(1);
    chk(A_LIVE, 32'd2, 1'b0, "R4 step on 4th pulse");
    refs(4);
    chk(A_LIVE, 32'd1, 1'b0, "R4 next step");
    refs(4);
    chk(A_LIVE, 32'd3, 1'b1, "R5 expiry at N=2");
    wr(A_PEND, 32'h1);
    chk(A_PEND, 32'd0, 1'b0, "R7 clear after N=2 expiry");

    // R9 select change mid-period
    refs(1);
    wr(A_CTRL, 32'h101);
    refs(2);
    chk(A_LIVE, 32'd3, 1'b0, "R9 old period still running");
    refs(1);
    chk(A_LIVE, 32'd2, 1'b0, "R9 old period completes");
    refs(1);
    chk(A_LIVE, 32'd1, 1'b0, "R9 new rate in effect");

    // R5 reload uses the count held at expiry
    wr(A_COUNT, 32'd7);
    chk(A_LIVE, 32'd1, 1'b0, "R5 live unaffected by count write");
    refs(1);
    chk(A_LIVE, 32'd7, 1'b1, "R5 reload uses new count");
    wr(A_PEND, 32'h1);

    // R6 stop on global enable fall
    wr(A_CTRL, 32'h100);
    chk(A_LIVE, 32'd0, 1'b0, "R6 global enable fall stops");
    refs(10);
    chk(A_LIVE, 32'd0, 1'b0, "R6 no expiry while stopped");
    wr(A_CTRL, 32'h101);
    chk(A_LIVE, 32'd0, 1'b0, "R3 no restart without tick edge");
    wr(A_CTRL, 32'h001);
    wr(A_CTRL, 32'h101);
    chk(A_LIVE, 32'd7, 1'b0, "R3 restart on tick edge");
    refs(3);
    chk(A_LIVE, 32'd4, 1'b0, "R4 steps after restart");

    // R1 reset in mid-run with the interrupt raised
    refs(4);
    chk(A_PEND, 32'd1, 1'b1, "R5 expiry before reset");
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    chk(A_CTRL,  32'h0, 1'b0, "R1 ctrl after mid-run reset");
    chk(A_COUNT, 32'h0, 1'b0, "R1 count after mid-run reset");
    chk(A_LIVE,  32'h0, 1'b0, "R1 live after mid-run reset");
    chk(A_PEND,  32'h0, 1'b0, "R1 pend after mid-run reset");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule